// File: doc/BRIEF.md
# Atomic Coefficient Commit Unit

This block collects up to five coefficient updates from a control port and writes them into coefficient memory as one group. A DSP program then never runs a frame with some coefficients new and others old. Each staging slot holds a 28-bit value and a target address. Setting one of two trigger bits queues a commit. One trigger sends the group to the parameter memory and the other sends it to the target/ramp memory.

The writes happen only in the closing steps of the DSP program frame, one slot per step. The frame position comes from a program counter input. A slot is written only if its data was reloaded since the last time that slot was committed. This lets software refresh a single coefficient without rewriting the others.

Top module: `coef_commit_unit`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, both write strobes and both pending flags are 0.
- R2: Writing a slot's data (`stageIsAddr`=0) marks that slot for commit. Writing only its address (`stageIsAddr`=1, address taken from `stageVal[ADDR_W-1:0]`) does not mark it, but the address is kept for later commits.
- R3: A one-cycle pulse on `trigParam` or `trigSlew` sets the matching pending flag in the next cycle.
- R4: Within a commit window, slot k is handled while `progCounter` equals FRAME_LEN-SLOTS+k (2555..2559 by default). If the slot is marked, one write strobe is high in the following cycle, carrying that slot's address and data.
- R5: An unmarked slot produces no strobe in its step.
- R6: A parameter-memory commit drives `paramWe` and a target-memory commit drives `slewWe`. The two are never high together.
- R7: A pending flag clears in the cycle after `progCounter`=FRAME_LEN-1 of the window that served it. A commit starts only if its flag is already set when the window opens (`progCounter`=FRAME_LEN-SLOTS). A trigger arriving later waits for the next full window.
- R8: If both flags are pending when a window opens, the parameter memory is served first. The target-memory commit is served in the following frame.
- R9: Committing a slot clears its mark, so a second commit with no new data writes nothing and still clears the pending flag.
- R10: If a data write to a slot lands in the same cycle as that slot's commit step, the commit carries the previous value. The slot stays marked with the new value.
- R11: A parameter-memory commit clears its pending flag within FRAME_LEN+SLOTS+1 cycles of its most recent trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| progCounter | input | PC_W (12) | DSP program step, counting 0..FRAME_LEN-1 |
| stageWrEn | input | 1 | Staging register write strobe |
| stageIsAddr | input | 1 | 1 writes the slot address, 0 writes the slot data |
| stageSlot | input | 3 | Staging slot index, 0..SLOTS-1 |
| stageVal | input | DATA_W (28) | Value to stage; the low ADDR_W bits are used for an address write |
| trigParam | input | 1 | Queue a commit into parameter memory |
| trigSlew | input | 1 | Queue a commit into target/ramp memory |
| paramWe | output | 1 | Parameter memory write strobe |
| slewWe | output | 1 | Target/ramp memory write strobe |
| memAddr | output | ADDR_W (10) | Write address |
| memData | output | DATA_W (28) | Write data |
| pendParam | output | 1 | Parameter commit queued |
| pendSlew | output | 1 | Target/ramp commit queued |

## Verification
The assertions assume the program counter steps by exactly one each cycle and wraps from FRAME_LEN-1 to 0. The window timing, latency bound and priority checks all depend on that. The stimulus drives the counter from a single task that advances it on every clock, including during reset, so the counter never jumps. Triggers and staging writes are placed at chosen counter values: before a window, in its opening cycle and partway through it. Staging slot indices are kept within 0..SLOTS-1.

// File: rtl/coef_commit_pkg.sv
package coef_commit_pkg;
  // slot index width; SLOTS must not exceed 2**SLOT_IDX_W
  localparam int SLOT_IDX_W = 3;

  typedef struct packed {
    logic                  go;      // a commit window step is active
    logic                  toSlew;  // destination: 1 target memory, 0 parameter memory
    logic [SLOT_IDX_W-1:0] slot;    // slot handled in this step
  } commit_strobe_t;
endpackage

// File: rtl/coef_commit_ctrl.sv
module coef_commit_ctrl
  import coef_commit_pkg::*;
#(
  parameter int FRAME_LEN = 2560,
  parameter int SLOTS     = 5,
  parameter int PC_W      = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] progCounter,
  input  logic            trigParam,
  input  logic            trigSlew,
  output commit_strobe_t  strobe,
  output logic            pendParam,
  output logic            pendSlew
);
  localparam logic [PC_W-1:0] WIN_FIRST = PC_W'(FRAME_LEN - SLOTS);
  localparam logic [PC_W-1:0] WIN_LAST  = PC_W'(FRAME_LEN - 1);

  logic atFirst, atLast, inWin;
  logic actValid, actSlew;
  logic curValid, curSlew;

  always_comb begin
    atFirst  = (progCounter == WIN_FIRST);
    atLast   = (progCounter == WIN_LAST);
    inWin    = (progCounter >= WIN_FIRST) && (progCounter <= WIN_LAST);
    // destination is chosen when the window opens; param has priority
    curValid = atFirst ? (pendParam | pendSlew) : (inWin & actValid);
    curSlew  = atFirst ? ~pendParam : actSlew;
    strobe.go     = curValid;
    strobe.toSlew = curSlew;
    strobe.slot   = SLOT_IDX_W'(progCounter - WIN_FIRST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actValid <= 1'b0;
      actSlew  <= 1'b0;
    end else if (atLast) begin
      actValid <= 1'b0;
    end else if (atFirst) begin
      actValid <= pendParam | pendSlew;
      actSlew  <= ~pendParam;
    end
  end

  logic doneParam, doneSlew;
  assign doneParam = atLast & curValid & ~curSlew;
  assign doneSlew  = atLast & curValid & curSlew;

  // a new trigger wins over the end-of-window clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendParam <= 1'b0;
      pendSlew  <= 1'b0;
    end else begin
      pendParam <= trigParam | (pendParam & ~doneParam);
      pendSlew  <= trigSlew  | (pendSlew  & ~doneSlew);
    end
  end
endmodule

// File: rtl/coef_commit_dp.sv
module coef_commit_dp
  import coef_commit_pkg::*;
#(
  parameter int SLOTS  = 5,
  parameter int DATA_W = 28,
  parameter int ADDR_W = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  stageWrEn,
  input  logic                  stageIsAddr,
  input  logic [SLOT_IDX_W-1:0] stageSlot,
  input  logic [DATA_W-1:0]     stageVal,
  input  commit_strobe_t        strobe,
  output logic                  paramWe,
  output logic                  slewWe,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [DATA_W-1:0]     memData
);
  logic [DATA_W-1:0] slotData [SLOTS];
  logic [ADDR_W-1:0] slotAddr [SLOTS];
  logic [SLOTS-1:0]  slotDirty;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic              wrHit, commitHit;
    logic [DATA_W-1:0] dataQ;
    logic [ADDR_W-1:0] addrQ;
    logic              dirtyQ;

    assign wrHit     = stageWrEn && (stageSlot == SLOT_IDX_W'(i));
    assign commitHit = strobe.go && (strobe.slot == SLOT_IDX_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dataQ <= '0;
        addrQ <= '0;
      end else if (wrHit) begin
        if (stageIsAddr) addrQ <= stageVal[ADDR_W-1:0];
        else             dataQ <= stageVal;
      end
    end

    // a fresh data write keeps the slot marked even in its commit step
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                     dirtyQ <= 1'b0;
      else if (wrHit && !stageIsAddr) dirtyQ <= 1'b1;
      else if (commitHit)            dirtyQ <= 1'b0;
    end

    assign slotData[i]  = dataQ;
    assign slotAddr[i]  = addrQ;
    assign slotDirty[i] = dirtyQ;
  end

  logic fire;
  assign fire = strobe.go && slotDirty[strobe.slot];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      paramWe <= 1'b0;
      slewWe  <= 1'b0;
      memAddr <= '0;
      memData <= '0;
    end else begin
      paramWe <= fire & ~strobe.toSlew;
      slewWe  <= fire &  strobe.toSlew;
      if (fire) begin
        memAddr <= slotAddr[strobe.slot];
        memData <= slotData[strobe.slot];
      end
    end
  end
endmodule

// File: rtl/coef_commit_unit.sv
module coef_commit_unit
  import coef_commit_pkg::*;
#(
  parameter int FRAME_LEN = 2560,
  parameter int SLOTS     = 5,
  parameter int PC_W      = 12,
  parameter int DATA_W    = 28,
  parameter int ADDR_W    = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PC_W-1:0]       progCounter,
  input  logic                  stageWrEn,
  input  logic                  stageIsAddr,
  input  logic [SLOT_IDX_W-1:0] stageSlot,
  input  logic [DATA_W-1:0]     stageVal,
  input  logic                  trigParam,
  input  logic                  trigSlew,
  output logic                  paramWe,
  output logic                  slewWe,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [DATA_W-1:0]     memData,
  output logic                  pendParam,
  output logic                  pendSlew
);
  commit_strobe_t strobe;

  coef_commit_ctrl #(
    .FRAME_LEN(FRAME_LEN), .SLOTS(SLOTS), .PC_W(PC_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .progCounter(progCounter),
    .trigParam(trigParam), .trigSlew(trigSlew),
    .strobe(strobe), .pendParam(pendParam), .pendSlew(pendSlew)
  );

  coef_commit_dp #(
    .SLOTS(SLOTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .stageWrEn(stageWrEn), .stageIsAddr(stageIsAddr),
    .stageSlot(stageSlot), .stageVal(stageVal),
    .strobe(strobe),
    .paramWe(paramWe), .slewWe(slewWe),
    .memAddr(memAddr), .memData(memData)
  );
endmodule

// File: rtl/coef_commit_chk.sv
module coef_commit_chk #(
  parameter int FRAME_LEN = 2560,
  parameter int SLOTS     = 5,
  parameter int PC_W      = 12
) (
  input logic            clk,
  input logic            rstN,
  input logic [PC_W-1:0] progCounter,
  input logic            trigParam,
  input logic            trigSlew,
  input logic            paramWe,
  input logic            slewWe,
  input logic            pendParam,
  input logic            pendSlew
);
  localparam logic [PC_W-1:0] WIN_FIRST = PC_W'(FRAME_LEN - SLOTS);
  localparam logic [PC_W-1:0] WIN_LAST  = PC_W'(FRAME_LEN - 1);
  localparam int LAT_MAX = FRAME_LEN + SLOTS + 1;

  // counter for the latency window, restarted by each trigger
  int waitCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          waitCnt <= 0;
    else if (trigParam) waitCnt <= 0;
    else if (pendParam) waitCnt <= waitCnt + 1;
    else                waitCnt <= 0;
  end

  // R4: input expectation, the program counter steps by one and wraps
  p_pc_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    progCounter == (($past(progCounter) == WIN_LAST) ? '0 : $past(progCounter) + 1'b1));

  p_we_window_r4: assert property (@(posedge clk) disable iff (!rstN)
    (paramWe || slewWe) |-> ($past(progCounter) >= WIN_FIRST));

  p_one_dest_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(paramWe && slewWe));

  p_trig_param_r3: assert property (@(posedge clk) disable iff (!rstN)
    trigParam |=> pendParam);

  p_trig_slew_r3: assert property (@(posedge clk) disable iff (!rstN)
    trigSlew |=> pendSlew);

  p_clear_at_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pendParam) |-> ($past(progCounter) == WIN_LAST));

  p_clear_slew_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pendSlew) |-> ($past(progCounter) == WIN_LAST));

  p_param_first_r8: assert property (@(posedge clk) disable iff (!rstN)
    (progCounter == WIN_FIRST && pendParam) |=> !slewWe);

  p_latency_r11: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= LAT_MAX);
endmodule

bind coef_commit_unit coef_commit_chk #(
  .FRAME_LEN(FRAME_LEN), .SLOTS(SLOTS), .PC_W(PC_W)
) u_chk (
  .clk(clk), .rstN(rstN), .progCounter(progCounter),
  .trigParam(trigParam), .trigSlew(trigSlew),
  .paramWe(paramWe), .slewWe(slewWe),
  .pendParam(pendParam), .pendSlew(pendSlew)
);

// File: tb/sim_coef_commit_unit.sv
module sim_coef_commit_unit;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME = 2560;
  localparam int SLOTS = 5;
  localparam int WS    = FRAME - SLOTS;
  localparam int LAST  = FRAME - 1;
  localparam int DW    = 28;
  localparam int AW    = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [11:0]   progCounter = '0;
  logic          stageWrEn = 1'b0;
  logic          stageIsAddr = 1'b0;
  logic [2:0]    stageSlot = '0;
  logic [DW-1:0] stageVal = '0;
  logic          trigParam = 1'b0;
  logic          trigSlew = 1'b0;
  logic          paramWe, slewWe, pendParam, pendSlew;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coef_commit_unit u0 (
    .clk(clk), .rstN(rstN), .progCounter(progCounter),
    .stageWrEn(stageWrEn), .stageIsAddr(stageIsAddr),
    .stageSlot(stageSlot), .stageVal(stageVal),
    .trigParam(trigParam), .trigSlew(trigSlew),
    .paramWe(paramWe), .slewWe(slewWe),
    .memAddr(memAddr), .memData(memData),
    .pendParam(pendParam), .pendSlew(pendSlew)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit            mPendP = 0, mPendS = 0;
  int            mDest = 0;          // 0 none, 1 parameter, 2 target
  logic [DW-1:0] mData [SLOTS];
  logic [AW-1:0] mAddr [SLOTS];
  bit            mDirty [SLOTS];
  bit            eWeP = 0, eWeS = 0;
  logic [AW-1:0] eAddr = '0;
  logic [DW-1:0] eData = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPendP = 0; mPendS = 0; mDest = 0; eWeP = 0; eWeS = 0;
      for (int i = 0; i < SLOTS; i++) begin
        mData[i] = '0; mAddr[i] = '0; mDirty[i] = 0;
      end
    end else begin
      int pcv;
      pcv = int'(progCounter);
      eWeP = 0; eWeS = 0;
      if (pcv == WS) mDest = mPendP ? 1 : (mPendS ? 2 : 0);
      if (pcv >= WS && mDest != 0 && mDirty[pcv - WS]) begin
        if (mDest == 1) eWeP = 1; else eWeS = 1;
        eAddr = mAddr[pcv - WS];
        eData = mData[pcv - WS];
        mDirty[pcv - WS] = 0;
      end
      if (pcv == LAST && mDest != 0) begin
        if (mDest == 1) mPendP = 0; else mPendS = 0;
        mDest = 0;
      end
      if (trigParam) mPendP = 1;
      if (trigSlew)  mPendS = 1;
      if (stageWrEn && int'(stageSlot) < SLOTS) begin
        if (stageIsAddr) mAddr[stageSlot] = stageVal[AW-1:0];
        else begin
          mData[stageSlot] = stageVal;
          mDirty[stageSlot] = 1;
        end
      end
    end
  end

  // per-cycle comparison and write log
  int cntP = 0, cntS = 0;
  logic [AW-1:0] qAddr[$];
  logic [DW-1:0] qData[$];

  always @(negedge clk) begin
    if (!finished) begin
      chk("R6", "paramWe", paramWe, eWeP);
      chk("R6", "slewWe", slewWe, eWeS);
      chk("R7", "pendParam", pendParam, mPendP);
      chk("R7", "pendSlew", pendSlew, mPendS);
      if (eWeP || eWeS) begin
        chk("R4", "memAddr", memAddr, eAddr);
        chk("R4", "memData", memData, eData);
      end
      if (paramWe) cntP++;
      if (slewWe)  cntS++;
      if (paramWe || slewWe) begin
        qAddr.push_back(memAddr);
        qData.push_back(memData);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
    progCounter = (progCounter == 12'(LAST)) ? '0 : progCounter + 1'b1;
    stageWrEn = 0; trigParam = 0; trigSlew = 0;
  endtask

  task automatic waitPc(input int v);
    while (int'(progCounter) != v) tick();
  endtask

  task automatic stage(input int slot, input bit isAddr, input logic [DW-1:0] val);
    stageWrEn = 1; stageIsAddr = isAddr; stageSlot = 3'(slot); stageVal = val;
    tick();
  endtask

  task automatic clearLog();
    cntP = 0; cntS = 0; qAddr.delete(); qData.delete();
  endtask

  task automatic passWindow();
    waitPc(LAST);
    tick();
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) tick();
    chk("R1", "paramWe in reset", paramWe, 0);
    chk("R1", "pendParam in reset", pendParam, 0);
    rstN = 1;
    tick();
    chk("R1", "slewWe after reset", slewWe, 0);
    chk("R1", "pendSlew after reset", pendSlew, 0);

    // R2 / R5: slots 0 and 2 carry data, slot 1 only an address
    stage(0, 1, 28'h010);
    stage(0, 0, 28'h1111111);
    stage(2, 1, 28'h3FF);
    stage(2, 0, 28'h2222222);
    stage(1, 1, 28'h055);
    trigParam = 1; tick();
    chk("R3", "pendParam after trigger", pendParam, 1);
    clearLog();
    passWindow();
    chk("R5", "param writes for two marked slots", cntP, 2);
    chk("R6", "no target writes", cntS, 0);
    if (qAddr.size() == 2) begin
      chk("R2", "first address", qAddr[0], 10'h010);
      chk("R4", "second address", qAddr[1], 10'h3FF);
      chk("R4", "second data", qData[1], 28'h2222222);
    end
    chk("R7", "pendParam cleared", pendParam, 0);

    // R9: commit with nothing new
    trigParam = 1; tick();
    clearLog();
    passWindow();
    chk("R9", "writes with no new data", cntP, 0);
    chk("R9", "pending still cleared", pendParam, 0);

    // R7 / R11: trigger partway through a window waits for the next one
    waitPc(WS + 2);
    trigParam = 1; tick();
    n = 1;
    stage(1, 0, 28'h0ABCDEF);
    n++;
    clearLog();
    passWindow();
    n += 2;
    chk("R7", "no writes in partial window", cntP, 0);
    chk("R7", "pending kept after partial window", pendParam, 1);
    while (pendParam && n < 3 * FRAME) begin tick(); n++; end
    chk("R11", "latency bound met", (n <= FRAME + SLOTS + 1), 1);
    chk("R2", "address-only slot kept its address", (qAddr.size() == 1) ? qAddr[0] : 0, 10'h055);

    // R8: both triggers together
    stage(3, 1, 28'h123);
    stage(3, 0, 28'h3333333);
    trigParam = 1; trigSlew = 1; tick();
    clearLog();
    passWindow();
    chk("R8", "param served first", cntP, 1);
    chk("R8", "target waits", cntS, 0);
    chk("R8", "target still pending", pendSlew, 1);
    stage(4, 1, 28'h2AA);
    stage(4, 0, 28'h4444444);
    clearLog();
    passWindow();
    chk("R8", "target served next frame", cntS, 1);
    chk("R6", "target address", (qAddr.size() == 1) ? qAddr[0] : 0, 10'h2AA);
    chk("R7", "pendSlew cleared", pendSlew, 0);

    // R10: data write in the slot's own commit step
    stage(0, 0, 28'hAAAAAAA);
    trigParam = 1; tick();
    clearLog();
    waitPc(WS);
    stage(0, 0, 28'h5555555);
    passWindow();
    chk("R10", "commit carries old value", (qData.size() == 1) ? qData[0] : 0, 28'hAAAAAAA);
    trigParam = 1; tick();
    clearLog();
    passWindow();
    chk("R10", "new value committed next", (qData.size() == 1) ? qData[0] : 0, 28'h5555555);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule